// File: doc/BRIEF.md
# Stream-Tagged Fetch Redirect Unit

This block is the address front end of an in-order pipeline. It produces sequential fetch addresses and stamps each fetch with two tags: a stream number and a prediction number. Two sources can steer it. One is a late branch resolution from the execute stage. The other is an early branch prediction from the decode side. The execute source always wins. A resolved branch advances both tags. A prediction advances only the prediction tag.

Each fetch first waits in a requests queue. It is then offered to instruction memory and moves into a transfers queue, where it waits for its line. Memory may finish lines in any order, because each completion names its transfer slot. Lines still leave strictly in issue order.

Wrong-path work is removed in two ways, and the queues are never flushed. An execute redirect marks every queued entry stale, and stale entries are discarded when they reach the head. A line filter then drops any line that is on the current stream but carries an outdated prediction number.

Top module: `fetch_stream_unit`

## Requirements
- R1: After reset the fetch address is RESET_PC, both tags are zero, `line_vld` and `mem_req_vld` are low, and the first line forwarded has address RESET_PC, stream 0 and prediction 0.
- R2: Without a redirect, every issued fetch uses the address of the previous fetch plus 4 and carries the current stream and prediction numbers. `rsv_take` pulses once for each fetch issued.
- R3: In a cycle where `nxt_slot_free` is low, `rsv_take` stays low and no fetch is issued.
- R4: An execute redirect (`ex_redir_vld`) loads the fetch address with `ex_redir_pc` and increments both the stream number and the prediction number by one. Both numbers wrap modulo 16.
- R5: A predictor redirect (`pd_redir_vld` without `ex_redir_vld`) loads the fetch address with `pd_redir_pc`, increments only the prediction number and leaves the stream number unchanged.
- R6: When both redirects arrive in the same cycle, the execute target is used and the prediction number is incremented only once.
- R7: No fetch is issued in a cycle that carries a redirect.
- R8: A queued request is offered to memory (`mem_req_vld`) only while `mem_busy` is low. `mem_req_slot` names the transfer slot that the line must be returned to.
- R9: Completions (`mem_rsp_vld`, `mem_rsp_slot`) may arrive in any order. Lines are forwarded only from the head of the transfers queue once that head is complete, so they leave in issue order. `line_vld` rises one cycle after the head becomes ready.
- R10: Fetches that are still queued when an execute redirect occurs, in either queue, are never forwarded.
- R11: A line whose stream number equals the current stream but whose prediction number differs from the current prediction number is dropped and not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_redir_vld | input | 1 | Execute-stage branch resolution requests a redirect |
| ex_redir_pc | input | 32 | Target address of the execute redirect |
| pd_redir_vld | input | 1 | Decode-side prediction requests a redirect |
| pd_redir_pc | input | 32 | Target address of the prediction redirect |
| nxt_slot_free | input | 1 | Next stage can reserve an input-buffer slot this cycle |
| rsv_take | output | 1 | A fetch is issued and one downstream slot is reserved |
| mem_busy | input | 1 | Instruction memory cannot accept a request |
| mem_req_vld | output | 1 | Request offered to memory this cycle |
| mem_req_addr | output | 32 | Fetch address of the offered request |
| mem_req_slot | output | SLOT_W | Transfer slot assigned to the request |
| mem_rsp_vld | input | 1 | Memory returns a line |
| mem_rsp_slot | input | SLOT_W | Transfer slot of the returned line |
| mem_rsp_line | input | 32 | Returned line data |
| line_vld | output | 1 | Forwarded line valid |
| line_addr | output | 32 | Address of the forwarded line |
| line_data | output | 32 | Data of the forwarded line |
| line_strm | output | 4 | Stream number of the forwarded line |
| line_prd | output | 4 | Prediction number of the forwarded line |

## Verification
The results become visible at different points:
- `rsv_take` is combinational, so it is valid in the same cycle as its inputs, and the fetch address and tags change at the next rising edge.
- A fetch taken at an edge is offered to memory from the following cycle, provided `mem_busy` is low.
- A completion sets its slot's done bit at the next edge.
- The line then appears on the outputs one cycle after its slot becomes the ready head.

The bench drives inputs just after each rising edge and samples at the falling edge. Because of this, every combinational result is read in the cycle it applies to, and every registered result is read in the cycle after the edge that loads it.

A scoreboard expects lines in order and waits for them to arrive rather than counting a fixed delay. Checks that something must not happen, such as no request while memory is busy, no fetch during a redirect, or a dropped line, are repeated at every falling edge across the whole window.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;

    localparam int ADDR_W     = 32;
    localparam int SEQ_W      = 4;
    localparam int LINE_W     = 32;
    localparam int FETCH_STEP = 4;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [SEQ_W-1:0]  seq_t;
    typedef logic [LINE_W-1:0] line_t;

    // which source steers the fetch address this cycle
    typedef enum logic [1:0] {
        STEER_HOLD = 2'd0,
        STEER_PRED = 2'd1,
        STEER_EXEC = 2'd2
    } steer_e;

    // tag carried by every fetch through both queues
    typedef struct packed {
        addr_t pc;
        seq_t  strm;
        seq_t  prd;
        logic  stale;
    } ftag_t;

    function automatic addr_t seq_next(input addr_t pc);
        return pc + addr_t'(FETCH_STEP);
    endfunction

    // a line survives unless killed, or on the live stream with an old prediction
    function automatic logic path_live(input ftag_t t, input seq_t s, input seq_t p);
        return !t.stale && !((t.strm == s) && (t.prd != p));
    endfunction

endpackage

// File: rtl/fsr_steer.sv
`timescale 1ns/1ps
module fsr_steer
    import fsr_pkg::*;
#(
    parameter addr_t RESET_PC = '0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   ex_vld,
    input  addr_t  ex_pc,
    input  logic   pd_vld,
    input  addr_t  pd_pc,
    input  logic   adv,
    output steer_e steer,
    output addr_t  cur_pc,
    output seq_t   cur_strm,
    output seq_t   cur_prd,
    output seq_t   nxt_strm,
    output seq_t   nxt_prd
);

    addr_t nxt_pc;

    // fixed priority: the resolved branch outranks the prediction
    always_comb begin
        if (ex_vld)      steer = STEER_EXEC;
        else if (pd_vld) steer = STEER_PRED;
        else             steer = STEER_HOLD;
    end

    always_comb begin
        nxt_pc   = cur_pc;
        nxt_strm = cur_strm;
        nxt_prd  = cur_prd;
        case (steer)
            STEER_EXEC: begin
                nxt_pc   = ex_pc;
                nxt_strm = cur_strm + seq_t'(1);
                nxt_prd  = cur_prd + seq_t'(1);
            end
            STEER_PRED: begin
                nxt_pc  = pd_pc;
                nxt_prd = cur_prd + seq_t'(1);
            end
            default: begin
                if (adv) nxt_pc = seq_next(cur_pc);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_pc   <= RESET_PC;
            cur_strm <= '0;
            cur_prd  <= '0;
        end else begin
            cur_pc   <= nxt_pc;
            cur_strm <= nxt_strm;
            cur_prd  <= nxt_prd;
        end
    end

endmodule

// File: rtl/fsr_req_fifo.sv
`timescale 1ns/1ps
module fsr_req_fifo
    import fsr_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  ftag_t push_tag,
    input  logic  pop,
    input  logic  kill,
    output ftag_t head,
    output logic  empty,
    output logic  full
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    ftag_t            slots [DEPTH];
    logic [IDX_W-1:0] rd_p;
    logic [IDX_W-1:0] wr_p;
    logic [CNT_W-1:0] cnt;
    logic             do_push;
    logic             do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign head    = slots[rd_p];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_p <= '0;
            wr_p <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wr_p <= (wr_p == LAST) ? '0 : wr_p + 1'b1;
            if (do_pop)  rd_p <= (rd_p == LAST) ? '0 : rd_p + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // payload: a kill marks everything held; a same-cycle push lands clean
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (kill) slots[i].stale <= 1'b1;
        end
        if (do_push) slots[wr_p] <= push_tag;
    end

endmodule

// File: rtl/fsr_xfer_q.sv
`timescale 1ns/1ps
module fsr_xfer_q
    import fsr_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  ftag_t            alloc_tag,
    output logic [IDX_W-1:0] alloc_slot,
    output logic             full,
    input  logic             rsp_vld,
    input  logic [IDX_W-1:0] rsp_slot,
    input  line_t            rsp_line,
    input  logic             kill,
    output logic             head_rdy,
    output ftag_t            head_tag,
    output line_t            head_line
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    ftag_t            tags  [DEPTH];
    line_t            lines [DEPTH];
    logic [DEPTH-1:0] done;
    logic [IDX_W-1:0] rd_p;
    logic [IDX_W-1:0] wr_p;
    logic [CNT_W-1:0] cnt;
    logic             do_alloc;
    ftag_t            tag_in;

    assign full       = (cnt == CNT_W'(DEPTH));
    assign alloc_slot = wr_p;
    assign do_alloc   = alloc && !full;
    assign head_rdy   = (cnt != '0) && done[rd_p];
    assign head_tag   = tags[rd_p];
    assign head_line  = lines[rd_p];

    // an entry crossing over during a kill is already on a dead path
    always_comb begin
        tag_in       = alloc_tag;
        tag_in.stale = alloc_tag.stale | kill;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_p <= '0;
            wr_p <= '0;
            cnt  <= '0;
            done <= '0;
        end else begin
            if (do_alloc) wr_p <= (wr_p == LAST) ? '0 : wr_p + 1'b1;
            if (head_rdy) rd_p <= (rd_p == LAST) ? '0 : rd_p + 1'b1;
            case ({do_alloc, head_rdy})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (rsp_vld)  done[rsp_slot] <= 1'b1;
            if (do_alloc) done[wr_p]     <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (kill) tags[i].stale <= 1'b1;
        end
        if (do_alloc) tags[wr_p] <= tag_in;
        if (rsp_vld)  lines[rsp_slot] <= rsp_line;
    end

endmodule

// File: rtl/fsr_line_filter.sv
`timescale 1ns/1ps
module fsr_line_filter
    import fsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  ftag_t tag,
    input  line_t line,
    input  logic  kill,
    input  seq_t  nxt_strm,
    input  seq_t  nxt_prd,
    output logic  line_vld,
    output addr_t line_addr,
    output line_t line_data,
    output seq_t  line_strm,
    output seq_t  line_prd
);

    logic keep;

    // judged against the tags in force once this cycle's redirect lands
    assign keep = take && !kill && path_live(tag, nxt_strm, nxt_prd);

    always_ff @(posedge clk) begin
        if (rst) line_vld <= 1'b0;
        else     line_vld <= keep;
    end

    always_ff @(posedge clk) begin
        if (keep) begin
            line_addr <= tag.pc;
            line_data <= line;
            line_strm <= tag.strm;
            line_prd  <= tag.prd;
        end
    end

endmodule

// File: rtl/fetch_stream_unit.sv
`timescale 1ns/1ps
module fetch_stream_unit #(
    parameter int QDEPTH = 4,
    parameter logic [fsr_pkg::ADDR_W-1:0] RESET_PC = 32'h0000_1000,
    localparam int SLOT_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ex_redir_vld,
    input  logic [fsr_pkg::ADDR_W-1:0] ex_redir_pc,
    input  logic                      pd_redir_vld,
    input  logic [fsr_pkg::ADDR_W-1:0] pd_redir_pc,
    input  logic                      nxt_slot_free,
    output logic                      rsv_take,
    input  logic                      mem_busy,
    output logic                      mem_req_vld,
    output logic [fsr_pkg::ADDR_W-1:0] mem_req_addr,
    output logic [SLOT_W-1:0]         mem_req_slot,
    input  logic                      mem_rsp_vld,
    input  logic [SLOT_W-1:0]         mem_rsp_slot,
    input  logic [fsr_pkg::LINE_W-1:0] mem_rsp_line,
    output logic                      line_vld,
    output logic [fsr_pkg::ADDR_W-1:0] line_addr,
    output logic [fsr_pkg::LINE_W-1:0] line_data,
    output logic [fsr_pkg::SEQ_W-1:0]  line_strm,
    output logic [fsr_pkg::SEQ_W-1:0]  line_prd
);
    import fsr_pkg::*;

    steer_e           steer;
    addr_t            cur_pc;
    seq_t             cur_strm;
    seq_t             cur_prd;
    seq_t             nxt_strm;
    seq_t             nxt_prd;
    logic             issue_fire;
    logic             send;
    logic             kill;
    logic             rq_empty;
    logic             rq_full;
    logic             xq_full;
    logic             xq_head_rdy;
    ftag_t            new_tag;
    ftag_t            rq_head;
    ftag_t            xq_head_tag;
    line_t            xq_head_line;
    logic [SLOT_W-1:0] xq_slot;

    assign kill       = (steer == STEER_EXEC);
    assign issue_fire = nxt_slot_free && (steer == STEER_HOLD) && !rq_full;
    assign send       = !rq_empty && !mem_busy && !xq_full;

    assign rsv_take     = issue_fire;
    assign mem_req_vld  = send;
    assign mem_req_addr = rq_head.pc;
    assign mem_req_slot = xq_slot;

    always_comb begin
        new_tag.pc    = cur_pc;
        new_tag.strm  = cur_strm;
        new_tag.prd   = cur_prd;
        new_tag.stale = 1'b0;
    end

    fsr_steer #(.RESET_PC(RESET_PC)) u_steer (
        .clk      (clk),
        .rst      (rst),
        .ex_vld   (ex_redir_vld),
        .ex_pc    (ex_redir_pc),
        .pd_vld   (pd_redir_vld),
        .pd_pc    (pd_redir_pc),
        .adv      (issue_fire),
        .steer    (steer),
        .cur_pc   (cur_pc),
        .cur_strm (cur_strm),
        .cur_prd  (cur_prd),
        .nxt_strm (nxt_strm),
        .nxt_prd  (nxt_prd)
    );

    fsr_req_fifo #(.DEPTH(QDEPTH)) u_reqs (
        .clk      (clk),
        .rst      (rst),
        .push     (issue_fire),
        .push_tag (new_tag),
        .pop      (send),
        .kill     (kill),
        .head     (rq_head),
        .empty    (rq_empty),
        .full     (rq_full)
    );

    fsr_xfer_q #(.DEPTH(QDEPTH)) u_xfers (
        .clk        (clk),
        .rst        (rst),
        .alloc      (send),
        .alloc_tag  (rq_head),
        .alloc_slot (xq_slot),
        .full       (xq_full),
        .rsp_vld    (mem_rsp_vld),
        .rsp_slot   (mem_rsp_slot),
        .rsp_line   (mem_rsp_line),
        .kill       (kill),
        .head_rdy   (xq_head_rdy),
        .head_tag   (xq_head_tag),
        .head_line  (xq_head_line)
    );

    fsr_line_filter u_filter (
        .clk       (clk),
        .rst       (rst),
        .take      (xq_head_rdy),
        .tag       (xq_head_tag),
        .line      (xq_head_line),
        .kill      (kill),
        .nxt_strm  (nxt_strm),
        .nxt_prd   (nxt_prd),
        .line_vld  (line_vld),
        .line_addr (line_addr),
        .line_data (line_data),
        .line_strm (line_strm),
        .line_prd  (line_prd)
    );

endmodule

// File: rtl/fetch_stream_unit_chk.sv
`timescale 1ns/1ps
module fetch_stream_unit_chk
    import fsr_pkg::*;
#(
    parameter addr_t RESET_PC = '0
) (
    input logic  clk,
    input logic  rst,
    input logic  ex_redir_vld,
    input addr_t ex_redir_pc,
    input logic  pd_redir_vld,
    input addr_t pd_redir_pc,
    input logic  nxt_slot_free,
    input logic  rsv_take,
    input logic  mem_busy,
    input logic  mem_req_vld,
    input logic  line_vld,
    input addr_t cur_pc,
    input seq_t  cur_strm,
    input seq_t  cur_prd,
    input logic  xq_head_rdy
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cur_pc == RESET_PC) && (cur_strm == '0) && (cur_prd == '0) && !line_vld);

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rsv_take && !ex_redir_vld && !pd_redir_vld) |=> (cur_pc == $past(cur_pc) + addr_t'(FETCH_STEP)));

    // R3
    blocked_chk: assert property (@(posedge clk) disable iff (rst)
        !nxt_slot_free |-> !rsv_take);

    // R4
    exec_redir_chk: assert property (@(posedge clk) disable iff (rst)
        ex_redir_vld |=> (cur_pc == $past(ex_redir_pc))
                      && (cur_strm == $past(cur_strm) + seq_t'(1))
                      && (cur_prd == $past(cur_prd) + seq_t'(1)));

    // R5
    pred_redir_chk: assert property (@(posedge clk) disable iff (rst)
        (pd_redir_vld && !ex_redir_vld) |=> (cur_pc == $past(pd_redir_pc))
                                         && $stable(cur_strm)
                                         && (cur_prd == $past(cur_prd) + seq_t'(1)));

    // R6
    exec_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_redir_vld && pd_redir_vld) |=> (cur_pc == $past(ex_redir_pc)));

    // R7
    redir_nofetch_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_redir_vld || pd_redir_vld) |-> !rsv_take);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_busy |-> !mem_req_vld);

    // R9
    head_order_chk: assert property (@(posedge clk) disable iff (rst)
        line_vld |-> $past(xq_head_rdy));

endmodule

bind fetch_stream_unit fetch_stream_unit_chk #(.RESET_PC(RESET_PC)) u_chk (.*);

// File: tb/fetch_stream_unit_bench.sv
`timescale 1ns/1ps
module fetch_stream_unit_bench;
    import fsr_pkg::*;

    localparam int          QD  = 4;
    localparam int          SW  = 2;
    localparam logic [31:0] RPC = 32'h0000_1000;
    localparam logic [31:0] KEY = 32'h5A5A_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ex_redir_vld = 1'b0;
    logic [31:0]   ex_redir_pc = '0;
    logic          pd_redir_vld = 1'b0;
    logic [31:0]   pd_redir_pc = '0;
    logic          nxt_slot_free = 1'b0;
    logic          rsv_take;
    logic          mem_busy = 1'b0;
    logic          mem_req_vld;
    logic [31:0]   mem_req_addr;
    logic [SW-1:0] mem_req_slot;
    logic          mem_rsp_vld = 1'b0;
    logic [SW-1:0] mem_rsp_slot = '0;
    logic [31:0]   mem_rsp_line = '0;
    logic          line_vld;
    logic [31:0]   line_addr;
    logic [31:0]   line_data;
    logic [3:0]    line_strm;
    logic [3:0]    line_prd;

    always #10 clk = ~clk;

    fetch_stream_unit #(.QDEPTH(QD), .RESET_PC(RPC)) u_fetch_stream_unit (
        .clk(clk), .rst(rst),
        .ex_redir_vld(ex_redir_vld), .ex_redir_pc(ex_redir_pc),
        .pd_redir_vld(pd_redir_vld), .pd_redir_pc(pd_redir_pc),
        .nxt_slot_free(nxt_slot_free), .rsv_take(rsv_take),
        .mem_busy(mem_busy), .mem_req_vld(mem_req_vld),
        .mem_req_addr(mem_req_addr), .mem_req_slot(mem_req_slot),
        .mem_rsp_vld(mem_rsp_vld), .mem_rsp_slot(mem_rsp_slot),
        .mem_rsp_line(mem_rsp_line),
        .line_vld(line_vld), .line_addr(line_addr), .line_data(line_data),
        .line_strm(line_strm), .line_prd(line_prd)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    // scoreboard of lines due, in order
    logic [31:0] q_addr [$];
    logic [3:0]  q_strm [$];
    logic [3:0]  q_prd  [$];
    string       q_rq   [$];

    task automatic expect_run(input logic [31:0] start, input int n,
                              input logic [3:0] s, input logic [3:0] p, input string rq);
        for (int k = 0; k < n; k++) begin
            q_addr.push_back(start + 32'(4 * k));
            q_strm.push_back(s);
            q_prd.push_back(p);
            q_rq.push_back(rq);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && line_vld) begin
            if (q_addr.size() == 0) begin
                check(1'b0, "R10/R11", "unexpected line", line_addr, 32'h0);
            end else begin
                logic [31:0] a;
                logic [3:0]  s;
                logic [3:0]  p;
                string       r;
                a = q_addr.pop_front();
                s = q_strm.pop_front();
                p = q_prd.pop_front();
                r = q_rq.pop_front();
                check(line_addr == a, r, "line address", line_addr, a);
                check(line_data == (a ^ KEY), r, "line data", line_data, a ^ KEY);
                check(line_strm == s, r, "stream number", 32'(line_strm), 32'(s));
                check(line_prd == p, r, "prediction number", 32'(line_prd), 32'(p));
            end
        end
    end

    // instruction memory model: answers one pending slot per cycle
    logic [SW-1:0] pend_slot [$];
    logic [31:0]   pend_addr [$];
    bit rsp_en  = 1'b1;
    bit rsp_rev = 1'b0;

    always @(negedge clk) begin
        mem_rsp_vld = 1'b0;
        if (rsp_en && pend_slot.size() > 0) begin
            logic [SW-1:0] s;
            logic [31:0]   a;
            if (rsp_rev) begin
                s = pend_slot.pop_back();
                a = pend_addr.pop_back();
            end else begin
                s = pend_slot.pop_front();
                a = pend_addr.pop_front();
            end
            mem_rsp_vld  = 1'b1;
            mem_rsp_slot = s;
            mem_rsp_line = a ^ KEY;
        end
        if (!rst && mem_req_vld) begin
            pend_slot.push_back(mem_req_slot);
            pend_addr.push_back(mem_req_addr);
        end
    end

    task automatic after_edge();
        @(posedge clk);
        #2;
    endtask

    task automatic issue_n(input int n);
        int k = 0;
        while (k < n) begin
            after_edge();
            nxt_slot_free = 1'b1;
            @(negedge clk);
            if (rsv_take) k++;
        end
        after_edge();
        nxt_slot_free = 1'b0;
    endtask

    task automatic redirect(input bit ex, input logic [31:0] ex_t,
                            input bit pd, input logic [31:0] pd_t);
        after_edge();
        ex_redir_vld  = ex;
        ex_redir_pc   = ex_t;
        pd_redir_vld  = pd;
        pd_redir_pc   = pd_t;
        nxt_slot_free = 1'b1;
        @(negedge clk);
        // R7: no fetch in a redirect cycle
        check(rsv_take == 1'b0, "R7", "fetch during redirect", 32'(rsv_take), 32'h0);
        after_edge();
        ex_redir_vld  = 1'b0;
        pd_redir_vld  = 1'b0;
        nxt_slot_free = 1'b0;
    endtask

    task automatic wait_drain(input string rq);
        int t = 0;
        while (q_addr.size() != 0 && t < 400) begin
            @(negedge clk);
            t++;
        end
        repeat (8) @(negedge clk);
        check(q_addr.size() == 0, rq, "lines still due", 32'(q_addr.size()), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1: quiet outputs after reset
        check(line_vld == 1'b0, "R1", "line_vld after reset", 32'(line_vld), 32'h0);
        check(mem_req_vld == 1'b0, "R1", "mem_req_vld after reset", 32'(mem_req_vld), 32'h0);

        // R3: no slot downstream, nothing issues
        repeat (4) begin
            @(negedge clk);
            check(rsv_take == 1'b0, "R3", "rsv_take while blocked", 32'(rsv_take), 32'h0);
            check(mem_req_vld == 1'b0, "R3", "request while blocked", 32'(mem_req_vld), 32'h0);
        end

        // R1 + R2: sequential run from the reset address, in-order memory
        expect_run(RPC, 1, 4'd0, 4'd0, "R1");
        expect_run(RPC + 32'd4, 5, 4'd0, 4'd0, "R2");
        issue_n(6);
        wait_drain("R2");

        // R9: four lines completed in reverse order still leave in order
        rsp_en  = 1'b0;
        rsp_rev = 1'b1;
        expect_run(RPC + 32'd24, 4, 4'd0, 4'd0, "R9");
        issue_n(4);
        repeat (6) @(negedge clk);
        check(line_vld == 1'b0, "R9", "line before completion", 32'(line_vld), 32'h0);
        rsp_en = 1'b1;
        wait_drain("R9");
        rsp_rev = 1'b0;

        // R8: memory busy holds requests back
        after_edge();
        mem_busy = 1'b1;
        expect_run(RPC + 32'd40, 2, 4'd0, 4'd0, "R8");
        issue_n(2);
        repeat (5) begin
            @(negedge clk);
            check(mem_req_vld == 1'b0, "R8", "request while busy", 32'(mem_req_vld), 32'h0);
        end
        after_edge();
        mem_busy = 1'b0;
        wait_drain("R8");

        // R5 + R11: prediction redirect, older-prediction lines are dropped
        rsp_en = 1'b0;
        issue_n(2);
        repeat (4) @(negedge clk);
        redirect(1'b0, 32'h0, 1'b1, 32'h0000_2000);
        expect_run(32'h0000_2000, 3, 4'd0, 4'd1, "R5/R11");
        issue_n(3);
        rsp_en = 1'b1;
        wait_drain("R11");

        // R4 + R10: execute redirect kills entries in both queues
        rsp_en = 1'b0;
        issue_n(1);
        repeat (3) @(negedge clk);
        after_edge();
        mem_busy = 1'b1;
        issue_n(1);
        redirect(1'b1, 32'h0000_3000, 1'b0, 32'h0);
        after_edge();
        mem_busy = 1'b0;
        expect_run(32'h0000_3000, 2, 4'd1, 4'd2, "R4/R10");
        issue_n(2);
        rsp_en = 1'b1;
        wait_drain("R10");

        // R6: both redirects together, execute target and single increments
        redirect(1'b1, 32'h0000_4000, 1'b1, 32'h0000_5000);
        expect_run(32'h0000_4000, 2, 4'd2, 4'd3, "R6");
        issue_n(2);
        wait_drain("R6");

        summary();
        $finish;
    end

endmodule